// File: doc/BRIEF.md
# Buffered Down-Counting Timer Bank

Five down-counting channels share one word-addressed register port. Each channel keeps a count buffer and a live counter. Channels 0 to 3 also have a compare buffer. Software writes the buffers first. It then loads a live counter by giving that channel's manual-update bit a 0-to-1 edge in the packed control register. Setting the start bit runs the channel. A running channel counts down by one on every cycle in which its tick enable is high.

A tick that finds the counter at 0 is an underflow. The underflow gives a one-cycle pulse on that channel's event output, which feeds an interrupt block outside this bank. After an underflow the channel either reloads from its count buffer or stops and clears its own start bit. Each of channels 0 to 3 drives a compare-based waveform output that can be inverted. Channel 4 has no inverter and no compare buffer, so its output toggles on each underflow.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads 0, every channel is stopped, and `event_o` and `pwm_o` are 0.
- R2: The byte map is as follows. Control is at 0x08. For channels 0 to 3, channel c has its count buffer at 0x0C+0xC*c, its compare buffer at 0x10+0xC*c and its read-only live count at 0x14+0xC*c. Channel 4 has its count buffer at 0x3C and its live count at 0x40. A written buffer reads back unchanged.
- R3: When a channel's manual-update bit goes from 0 to 1 in a control write, the live counter takes the count buffer value at that clock edge. A write that leaves the bit at 1 does not reload the counter.
- R4: The start bit at the group's offset +0 runs the channel from the next cycle. While running, the counter drops by one on each tick. Clearing the start bit halts the counter, which keeps its value.
- R5: A tick that finds a running counter at 0 gives a one-cycle pulse on `event_o[c]` in the following cycle.
- R6: When the auto-reload bit is 1 (offset +3, or bit 22 for channel 4), an underflow reloads the count buffer and the channel keeps running. The period is then buffer+1 ticks.
- R7: When the auto-reload bit is 0, an underflow stops the channel, clears its start bit in the control register and leaves the counter at 0.
- R8: Channel 4 uses control bits 20 (start), 21 (manual update) and 22 (auto-reload). Its `pwm_o[4]` starts at 0 and toggles on each underflow.
- R9: Reads from unmapped offsets, including 0x00 and 0x44, return 0. Writes to unmapped offsets and to live-count offsets change nothing. Control bits 4 to 7 and 23 to 31 always read 0.
- R10: For channels 0 to 3, `pwm_o[c]` is (running and live count <= compare buffer), XORed with the invert bit at the group's offset +2.
- R11: Ticks have no effect on a stopped channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 5 | Per-channel count enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| event_o | output | 5 | One-cycle underflow pulse per channel |
| pwm_o | output | 5 | Per-channel waveform output |

## Verification
The counting path is first driven with a one-shot run of buffer 5 and auto-reload clear. This shows whether an underflow stops the channel, clears its start bit and pulses its event. A second run uses buffer 2 with auto-reload set. It separates a correct reload period of three ticks from a counter that stops early or reloads one tick late. Control writes that hold the manual-update bit at 1, and ticks given to stopped channels, tell edge-triggered behaviour apart from level-triggered behaviour. Channel 4 and the undefined control bits are driven on their own, because their layout breaks the pattern the other channels follow.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int N_CH     = 5;
  localparam int LAST_CH  = N_CH - 1;
  localparam int OFF_CTRL = 'h08;

  typedef enum logic [2:0] {
    RK_NONE, RK_CTRL, RK_CBUF, RK_MBUF, RK_LIVE
  } reg_kind_e;

  function automatic int grp_base(int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int start_bit(int ch);
    return grp_base(ch);
  endfunction

  function automatic int mupd_bit(int ch);
    return grp_base(ch) + 1;
  endfunction

  function automatic int inv_bit(int ch);
    return grp_base(ch) + 2;
  endfunction

  // last channel has no inverter, its reload bit moves down one
  function automatic int arel_bit(int ch);
    return (ch == LAST_CH) ? grp_base(ch) + 2 : grp_base(ch) + 3;
  endfunction

  function automatic logic [31:0] ctrl_mask();
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < N_CH; c++) begin
      m[start_bit(c)] = 1'b1;
      m[mupd_bit(c)]  = 1'b1;
      m[arel_bit(c)]  = 1'b1;
      if (c != LAST_CH) m[inv_bit(c)] = 1'b1;
    end
    return m;
  endfunction

  function automatic int cbuf_off(int ch);
    return 'h0C + 'hC * ch;
  endfunction

  function automatic int mbuf_off(int ch);
    return 'h10 + 'hC * ch;
  endfunction

  function automatic int live_off(int ch);
    return (ch == LAST_CH) ? cbuf_off(ch) + 4 : 'h14 + 'hC * ch;
  endfunction
endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
  import tmr_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    kind_o = RK_NONE;
    idx_o  = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) kind_o = RK_CTRL;
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == ADDR_W'(cbuf_off(c))) begin
        kind_o = RK_CBUF;
        idx_o  = IDX_W'(c);
      end
      if (c != LAST_CH && addr_i == ADDR_W'(mbuf_off(c))) begin
        kind_o = RK_MBUF;
        idx_o  = IDX_W'(c);
      end
      if (addr_i == ADDR_W'(live_off(c))) begin
        kind_o = RK_LIVE;
        idx_o  = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/tmr_bank_ctrl.sv
module tmr_bank_ctrl
  import tmr_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_CH-1:0]   uflow_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [N_CH-1:0]   run_o,
  output logic [N_CH-1:0]   ld_o,
  output logic [N_CH-1:0]   arel_o,
  output logic [N_CH-1:0]   inv_o
);
  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(ctrl_mask());

  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) begin
      ctrl_d = wdata_i & CTRL_MASK;
    end else begin
      for (int c = 0; c < N_CH; c++)
        if (uflow_i[c] && !ctrl_q[arel_bit(c)]) ctrl_d[start_bit(c)] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_bits
    localparam int SB = start_bit(c);
    localparam int MB = mupd_bit(c);
    localparam int AB = arel_bit(c);
    assign run_o[c]  = ctrl_q[SB];
    assign arel_o[c] = ctrl_q[AB];
    assign ld_o[c]   = we_i && wdata_i[MB] && !ctrl_q[MB];
    if (c != LAST_CH) begin : g_inv
      assign inv_o[c] = ctrl_q[inv_bit(c)];
    end else begin : g_noinv
      assign inv_o[c] = 1'b0;
    end

    // R7
    one_shot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uflow_i[c] && !arel_o[c] && !we_i |=> !run_o[c]);
    // R6
    reload_keeps_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uflow_i[c] && arel_o[c] && !we_i |=> run_o[c]);
  end
endmodule

// File: rtl/tmr_bank_chan.sv
module tmr_bank_chan #(
  parameter int DATA_W  = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              ld_i,
  input  logic              arel_i,
  input  logic              inv_i,
  input  logic              wr_cbuf_i,
  input  logic              wr_mbuf_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] cbuf_o,
  output logic [DATA_W-1:0] mbuf_o,
  output logic              uflow_o,
  output logic              event_o,
  output logic              pwm_o
);
  logic [DATA_W-1:0] cnt_q, cbuf_q;
  logic              ev_q;

  assign uflow_o = run_i && tick_i && !ld_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cbuf_q <= '0;
      ev_q   <= 1'b0;
    end else begin
      ev_q <= uflow_o;
      if (wr_cbuf_i) cbuf_q <= wdata_i;
      if (ld_i) begin
        cnt_q <= cbuf_q;
      end else if (run_i && tick_i) begin
        if (cnt_q != '0)  cnt_q <= cnt_q - DATA_W'(1);
        else if (arel_i)  cnt_q <= cbuf_q;
      end
    end
  end

  if (HAS_CMP) begin : g_cmp
    logic [DATA_W-1:0] mbuf_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mbuf_q <= '0;
      else if (wr_mbuf_i) mbuf_q <= wdata_i;
    end
    assign mbuf_o = mbuf_q;
    assign pwm_o  = (run_i && (cnt_q <= mbuf_q)) ^ inv_i;
  end else begin : g_tog
    logic tog_q;
    logic unused_in;
    assign unused_in = wr_mbuf_i ^ inv_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tog_q <= 1'b0;
      else if (uflow_o) tog_q <= ~tog_q;
    end
    assign mbuf_o = '0;
    assign pwm_o  = tog_q;
  end

  assign cnt_o   = cnt_q;
  assign cbuf_o  = cbuf_q;
  assign event_o = ev_q;

  // R3
  manual_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !wr_cbuf_i |=> cnt_q == $past(cbuf_q));
  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !ld_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - DATA_W'(1));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !ld_i |=> $stable(cnt_q));
  // R6
  reload_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_o && arel_i |=> cnt_q == $past(cbuf_q));
  // R5
  event_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(run_i && tick_i && cnt_q == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   event_o,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int IDX_W = $clog2(N_CH);

  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  ctrl;
  logic [N_CH-1:0]    run, ld, arel, inv, uflow;
  logic [DATA_W-1:0]  cnt  [N_CH];
  logic [DATA_W-1:0]  cbuf [N_CH];
  logic [DATA_W-1:0]  mbuf [N_CH];

  tmr_bank_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr_i (addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  tmr_bank_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && kind == RK_CTRL),
    .wdata_i (wdata_i),
    .uflow_i (uflow),
    .ctrl_o  (ctrl),
    .run_o   (run),
    .ld_o    (ld),
    .arel_o  (arel),
    .inv_o   (inv)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = we_i && (idx == IDX_W'(c));
    tmr_bank_chan #(.DATA_W(DATA_W), .HAS_CMP(c != LAST_CH)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i[c]),
      .run_i     (run[c]),
      .ld_i      (ld[c]),
      .arel_i    (arel[c]),
      .inv_i     (inv[c]),
      .wr_cbuf_i (hit && kind == RK_CBUF),
      .wr_mbuf_i (hit && kind == RK_MBUF),
      .wdata_i   (wdata_i),
      .cnt_o     (cnt[c]),
      .cbuf_o    (cbuf[c]),
      .mbuf_o    (mbuf[c]),
      .uflow_o   (uflow[c]),
      .event_o   (event_o[c]),
      .pwm_o     (pwm_o[c])
    );

    // R5
    event_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_o[c] |-> $past(run[c] && tick_i[c]));
  end

  always_comb begin
    rdata_o = '0;
    if (int'(idx) < N_CH) begin
      unique case (kind)
        RK_CTRL: rdata_o = ctrl;
        RK_CBUF: rdata_o = cbuf[idx];
        RK_MBUF: rdata_o = mbuf[idx];
        RK_LIVE: rdata_o = cnt[idx];
        default: rdata_o = '0;
      endcase
    end
  end

  // R9
  ctrl_undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[7:4] == 4'h0 && ctrl[DATA_W-1:23] == '0);
endmodule

// File: tb/tmr_bank_bench.sv
`timescale 1ns/1ps
module tmr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  tick_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [4:0]  event_o, pwm_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 rdata, 1 event, 2 pwm
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .event_o(event_o), .pwm_o(pwm_o)
  );

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rdata_o;
        1:       act = {27'd0, event_o};
        default: act = {27'd0, pwm_o};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  // driver tasks: entered and left at posedge + 1ns
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    we_i = 1'b0;
  endtask

  task automatic tick(input logic [4:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = m;
      @(posedge clk); #1;
      tick_i = '0;
    end
  endtask

  task automatic expect_item(input int k, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr_i = a;
    expect_item(0, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(8'h08, 32'h0, "R1 ctrl");
    rd(8'h0C, 32'h0, "R1 cbuf0");
    rd(8'h14, 32'h0, "R1 live0");
    expect_item(1, 32'h0, "R1 event");
    expect_item(2, 32'h0, "R1 pwm");

    // R2 map and readback
    wr(8'h0C, 32'd5);
    wr(8'h10, 32'd2);
    wr(8'h3C, 32'd3);
    rd(8'h0C, 32'd5, "R2 cbuf0");
    rd(8'h10, 32'd2, "R2 mbuf0");
    rd(8'h3C, 32'd3, "R2 cbuf4");
    // R9 unmapped
    wr(8'h00, 32'hFF);
    rd(8'h00, 32'h0, "R9 off00");
    rd(8'h44, 32'h0, "R9 off44");

    // R3 manual update
    wr(8'h08, 32'h2);
    rd(8'h14, 32'd5, "R3 load");
    tick(5'b00001, 2);
    rd(8'h14, 32'd5, "R11 stopped tick");
    wr(8'h08, 32'h3);
    rd(8'h14, 32'd5, "R3 held level no reload");
    tick(5'b00001, 1);
    rd(8'h14, 32'd4, "R4 decrement");
    expect_item(2, 32'h0, "R10 pwm above cmp");
    tick(5'b00001, 2);
    expect_item(2, 32'h1, "R10 pwm at cmp");
    tick(5'b00001, 2);
    rd(8'h14, 32'd0, "R4 reach zero");
    tick(5'b00001, 1);
    expect_item(1, 32'h1, "R5 event ch0");
    rd(8'h08, 32'h2, "R7 start cleared");
    rd(8'h14, 32'd0, "R7 counter at 0");
    tick(5'b00001, 1);
    expect_item(1, 32'h0, "R11 no event stopped");

    // R6 auto-reload
    wr(8'h0C, 32'd2);
    wr(8'h08, 32'h8);
    wr(8'h08, 32'hB);
    rd(8'h14, 32'd2, "R3 reload by edge");
    tick(5'b00001, 3);
    expect_item(1, 32'h1, "R6 first underflow");
    rd(8'h14, 32'd2, "R6 reloaded");
    rd(8'h08, 32'hB, "R6 still started");
    tick(5'b00001, 2);
    expect_item(1, 32'h0, "R6 no early event");
    tick(5'b00001, 1);
    expect_item(1, 32'h1, "R6 period");
    wr(8'h08, 32'hF);
    expect_item(2, 32'h0, "R10 inverted running");
    wr(8'h08, 32'h4);
    expect_item(2, 32'h1, "R10 inverted stopped");
    rd(8'h14, 32'd2, "R4 halt value");
    tick(5'b00001, 1);
    rd(8'h14, 32'd2, "R4 halted");

    // R8 last channel
    wr(8'h08, 32'h0020_0000);
    rd(8'h40, 32'd3, "R8 load ch4");
    wr(8'h40, 32'h55);
    rd(8'h40, 32'd3, "R9 live write ignored");
    wr(8'h08, 32'h0070_0000);
    tick(5'b10000, 4);
    expect_item(1, 32'h10, "R8 event ch4");
    expect_item(2, 32'h10, "R8 toggle ch4");
    rd(8'h40, 32'd3, "R8 reload ch4");
    rd(8'h08, 32'h0070_0000, "R8 ctrl");

    // R9 undefined ctrl bits
    wr(8'h08, 32'h0080_00F0);
    rd(8'h08, 32'h0, "R9 ctrl mask");

    // R2 other channels
    wr(8'h18, 32'd7);
    wr(8'h1C, 32'h11);
    rd(8'h1C, 32'h11, "R2 mbuf1");
    wr(8'h08, 32'h200);
    rd(8'h20, 32'd7, "R2 live1");
    wr(8'h30, 32'hA);
    wr(8'h08, 32'h2_0000);
    rd(8'h38, 32'hA, "R2 live3");

    @(posedge clk); #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule